// File: doc/BRIEF.md
# Cyclic-Prefix Correlation Symbol Synchronizer

This block locates OFDM symbol boundaries in a stream of complex baseband samples without any known preamble. Each accepted sample is multiplied by the complex conjugate of the sample received one useful-symbol length earlier. A running sum of these products covers the most recent cyclic-prefix-length products. When the window lies exactly over a cyclic prefix and its copy at the end of the symbol, the sum peaks. The block searches every full symbol period for the window with the largest sum, measured as |re|+|im|.

At the end of each period the block pulses a strobe for one cycle. With the strobe it gives the index, inside the period, of the first sample after the detected cyclic prefix, and the complex sum at the peak. A later stage can take the phase of that sum to estimate the carrier frequency offset. That later stage is not part of this block. With the defaults, the useful length is 256 samples, the prefix is 144 samples and a period is 400 samples. The input is 16-bit signed I/Q.

Top module: `cps_symbol_sync`

## Requirements
- R1: While `rst` is high and after it is released, `sym_done` is 0 and `peak_idx`, `peak_re` and `peak_im` are 0. The first sample accepted after reset has in-period index 0.
- R2: The product for sample n is x[n]·conj(x[n−256]), with re = ar·br + ai·bi and im = ai·br − ar·bi. Here a is the new sample and b is the delayed one. Samples older than the first accepted since reset count as zero.
- R3: The reported sum is the exact sum of the 144 most recent products. With every input at −32768 on both rails, the full-window sum is 144·2^31 on the real part and 0 on the imaginary part, with no wrap-around.
- R4: `sym_done` is high for exactly one cycle per 400 accepted samples. It becomes visible after the third rising edge that follows the edge accepting the sample with in-period index 399.
- R5: `peak_idx` = (e + 145) mod 400, where e is the in-period index of the sample that ends the winning window. For a noise-free stream whose prefix starts at in-period index s, the result is (s + 144) mod 400. For s = 0 it is 144.
- R6: `peak_re`/`peak_im` equal the window sum at the winning position. For a pure-delay stream the imaginary part is 0. When the prefix is the useful tail rotated by −90°, the real part is 0 and the imaginary part is positive.
- R7: When two window positions in a period have equal |re|+|im|, the earlier one is reported.
- R8: The peak is chosen by |re|+|im|, so a sum that is purely imaginary competes on equal terms with a purely real one.
- R9: Cycles with `in_valid` low change nothing. Results are identical to the same samples with no gaps between them.
- R10: The peak search restarts each period. The result of one period does not depend on the sums seen in earlier periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present on `in_re`/`in_im` this cycle |
| in_re | input | 16 | Real part of the sample, signed |
| in_im | input | 16 | Imaginary part of the sample, signed |
| sym_done | output | 1 | One-cycle strobe at the end of each search period |
| peak_idx | output | 9 | First sample after the detected prefix, as an in-period index |
| peak_re | output | 41 | Real part of the window sum at the peak, signed |
| peak_im | output | 41 | Imaginary part of the window sum at the peak, signed |

## Verification
Two functions can fall in the same cycle: the peak comparison for the last window of a period, and the emission of that period's result followed by the tracker restart. A stream whose prefix starts at index 0 puts the true peak on that very last sample. A constant full-scale stream makes the first period's largest sum fall on the last sample and every later position tie. The reported index is then judged against a brute-force window model kept in the bench: 144 on the first period and 145 afterwards. This shows that the last candidate is both compared and emitted, and that the next period starts from scratch.

// File: rtl/cps_pkg.sv
package cps_pkg;
  localparam int CPS_DW   = 16;
  localparam int CPS_NFFT = 256;
  localparam int CPS_NCP  = 144;

  // width of one conjugate product component
  function automatic int prod_width(input int dw);
    return 2 * dw + 1;
  endfunction

  // width of the window accumulator: room for ncp full-scale products
  function automatic int acc_width(input int dw, input int ncp);
    return 2 * dw + 1 + $clog2(ncp);
  endfunction
endpackage

// File: rtl/cps_delay_ram.sv
// Fixed-length delay line built on a circular buffer with read-first access,
// written so that a block RAM can hold it. Output is zero until primed.
module cps_delay_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 256,
  localparam int PTRW = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] ptr;
  logic            primed;

  always_ff @(posedge clk) begin
    if (en) mem[ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      primed <= 1'b0;
      dout   <= '0;
    end else if (en) begin
      dout <= primed ? mem[ptr] : '0;
      if (ptr == PTRW'(DEPTH - 1)) begin
        ptr    <= '0;
        primed <= 1'b1;
      end else begin
        ptr <= ptr + PTRW'(1);
      end
    end
  end

  // R9: an idle cycle must not advance the delay line
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(ptr) && $stable(dout));
endmodule

// File: rtl/cps_conj_mult.sv
// Complex multiply of a by the conjugate of b, full precision.
module cps_conj_mult #(
  parameter int DW  = 16,
  localparam int PW = 2 * DW + 1
) (
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  output logic signed [PW-1:0] p_re,
  output logic signed [PW-1:0] p_im
);
  logic signed [2*DW-1:0] m_rr, m_ii, m_ir, m_ri;

  always_comb begin
    m_rr = a_re * b_re;
    m_ii = a_im * b_im;
    m_ir = a_im * b_re;
    m_ri = a_re * b_im;
    p_re = PW'(m_rr) + PW'(m_ii);
    p_im = PW'(m_ir) - PW'(m_ri);
  end
endmodule

// File: rtl/cps_peak_track.sv
// Tracks the largest |re|+|im| over one search period, first wins on ties,
// and emits the result with a one-cycle strobe on the period's last sample.
module cps_peak_track #(
  parameter int AW  = 41,
  parameter int IW  = 9,
  parameter int SYM = 400
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_v,
  input  logic                 in_last,
  input  logic [IW-1:0]        in_idx,
  input  logic signed [AW-1:0] in_re,
  input  logic signed [AW-1:0] in_im,
  output logic                 out_done,
  output logic [IW-1:0]        out_idx,
  output logic signed [AW-1:0] out_re,
  output logic signed [AW-1:0] out_im
);
  logic [AW-1:0]        abs_re, abs_im;
  logic [AW:0]          mag, best_mag, cand_mag;
  logic                 fresh, take;
  logic [IW-1:0]        best_idx, cand_idx;
  logic signed [AW-1:0] best_re, best_im, cand_re, cand_im;

  always_comb begin
    abs_re   = in_re[AW-1] ? AW'(-in_re) : AW'(in_re);
    abs_im   = in_im[AW-1] ? AW'(-in_im) : AW'(in_im);
    mag      = {1'b0, abs_re} + {1'b0, abs_im};
    take     = fresh || (mag > best_mag);
    cand_mag = take ? mag    : best_mag;
    cand_idx = take ? in_idx : best_idx;
    cand_re  = take ? in_re  : best_re;
    cand_im  = take ? in_im  : best_im;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh    <= 1'b1;
      best_mag <= '0;
      best_idx <= '0;
      best_re  <= '0;
      best_im  <= '0;
      out_done <= 1'b0;
      out_idx  <= '0;
      out_re   <= '0;
      out_im   <= '0;
    end else begin
      out_done <= 1'b0;
      if (in_v) begin
        if (in_last) begin
          out_done <= 1'b1;
          out_idx  <= cand_idx;
          out_re   <= cand_re;
          out_im   <= cand_im;
          fresh    <= 1'b1;
        end else begin
          fresh    <= 1'b0;
          best_mag <= cand_mag;
          best_idx <= cand_idx;
          best_re  <= cand_re;
          best_im  <= cand_im;
        end
      end
    end
  end

  // R7: an equal metric later in the period leaves the held index alone
  p_tie_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (in_v && !fresh && !in_last && mag == best_mag) |=> best_idx == $past(best_idx));
  // R4: the strobe lasts one cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    out_done |=> !out_done);
  // R5: reported index lies inside the period
  p_idx_range_r5: assert property (@(posedge clk) disable iff (rst)
    out_done |-> out_idx < IW'(SYM));
endmodule

// File: rtl/cps_symbol_sync.sv
module cps_symbol_sync
  import cps_pkg::*;
#(
  parameter int DW   = CPS_DW,
  parameter int NFFT = CPS_NFFT,
  parameter int NCP  = CPS_NCP,
  localparam int SYM = NFFT + NCP,
  localparam int IW  = $clog2(SYM),
  localparam int AW  = acc_width(DW, NCP)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 sym_done,
  output logic [IW-1:0]        peak_idx,
  output logic signed [AW-1:0] peak_re,
  output logic signed [AW-1:0] peak_im
);
  localparam int PW = prod_width(DW);
  localparam logic signed [AW-1:0] ACC_LIM = AW'(NCP) <<< (2 * DW - 1);

  // in-period sample counter
  logic [IW-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst)                            cnt <= '0;
    else if (in_valid && cnt == IW'(SYM - 1)) cnt <= '0;
    else if (in_valid)                  cnt <= cnt + IW'(1);
  end

  // stage 1: current sample and its copy one useful length back
  logic [2*DW-1:0]      dly_smp;
  logic signed [DW-1:0] x1_re, x1_im, d1_re, d1_im;
  logic                 v1;
  logic [IW-1:0]        e1;

  cps_delay_ram #(.W(2 * DW), .DEPTH(NFFT)) u_dly_smp (
    .clk (clk), .rst (rst), .en (in_valid),
    .din ({in_re, in_im}), .dout (dly_smp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; e1 <= '0; x1_re <= '0; x1_im <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        x1_re <= in_re;
        x1_im <= in_im;
        e1    <= cnt;
      end
    end
  end

  assign d1_re = $signed(dly_smp[2*DW-1:DW]);
  assign d1_im = $signed(dly_smp[DW-1:0]);

  logic signed [PW-1:0] p_re, p_im;
  cps_conj_mult #(.DW(DW)) u_cmul (
    .a_re (x1_re), .a_im (x1_im), .b_re (d1_re), .b_im (d1_im),
    .p_re (p_re),  .p_im (p_im)
  );

  // stage 2: newest product and the one leaving the window
  logic [2*PW-1:0]      old_prd;
  logic signed [PW-1:0] p2_re, p2_im, o2_re, o2_im;
  logic                 v2;
  logic [IW-1:0]        e2;

  cps_delay_ram #(.W(2 * PW), .DEPTH(NCP)) u_dly_prd (
    .clk (clk), .rst (rst), .en (v1),
    .din ({p_re, p_im}), .dout (old_prd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= 1'b0; e2 <= '0; p2_re <= '0; p2_im <= '0;
    end else begin
      v2 <= v1;
      if (v1) begin
        p2_re <= p_re;
        p2_im <= p_im;
        e2    <= e1;
      end
    end
  end

  assign o2_re = $signed(old_prd[2*PW-1:PW]);
  assign o2_im = $signed(old_prd[PW-1:0]);

  // stage 3: running window sum
  logic signed [AW-1:0] acc_re, acc_im;
  logic                 v3;
  logic [IW-1:0]        e3, st3;

  always_ff @(posedge clk) begin
    if (rst) begin
      v3 <= 1'b0; e3 <= '0; acc_re <= '0; acc_im <= '0;
    end else begin
      v3 <= v2;
      if (v2) begin
        acc_re <= acc_re + AW'(p2_re) - AW'(o2_re);
        acc_im <= acc_im + AW'(p2_im) - AW'(o2_im);
        e3     <= e2;
      end
    end
  end

  // window end index -> first sample after the prefix, modulo the period
  always_comb begin
    if (e3 >= IW'(NFFT - 1)) st3 = e3 - IW'(NFFT - 1);
    else                     st3 = e3 + IW'(NCP + 1);
  end

  cps_peak_track #(.AW(AW), .IW(IW), .SYM(SYM)) u_track (
    .clk      (clk),
    .rst      (rst),
    .in_v     (v3),
    .in_last  (e3 == IW'(SYM - 1)),
    .in_idx   (st3),
    .in_re    (acc_re),
    .in_im    (acc_im),
    .out_done (sym_done),
    .out_idx  (peak_idx),
    .out_re   (peak_re),
    .out_im   (peak_im)
  );

  // R9: idle cycles leave the period position untouched
  p_gap_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(cnt));
  // R3: the window sum never leaves the range of NCP full-scale products
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    v3 |-> (acc_re <= ACC_LIM && acc_re >= -ACC_LIM &&
            acc_im <= ACC_LIM && acc_im >= -ACC_LIM));
endmodule

// File: tb/cps_symbol_sync_tb.sv
module cps_symbol_sync_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW   = 16;
  localparam int NFFT = 256;
  localparam int NCP  = 144;
  localparam int SYM  = NFFT + NCP;
  localparam int AW   = 2 * DW + 1 + $clog2(NCP);
  localparam int NPER = 3;
  localparam int NS   = SYM * NPER;
  localparam int NCASE = 5;

  // mode 0: pure delay, mode 1: prefix rotated by -90 deg, mode 2: constant full scale
  typedef struct packed {
    int off;
    int mode;
    int gaps;
    int exp_idx;
  } case_t;

  localparam case_t CASES [NCASE] = '{
    '{0,   0, 0, 144},
    '{37,  0, 0, 181},
    '{300, 1, 0, 44},
    '{123, 0, 1, 267},
    '{0,   2, 0, 145}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_re = '0;
  logic signed [DW-1:0] in_im = '0;
  logic sym_done;
  logic [8:0] peak_idx;
  logic signed [AW-1:0] peak_re, peak_im;

  cps_symbol_sync u_dut (
    .clk (clk), .rst (rst), .in_valid (in_valid),
    .in_re (in_re), .in_im (in_im),
    .sym_done (sym_done), .peak_idx (peak_idx),
    .peak_re (peak_re), .peak_im (peak_im)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  int unsigned lf = 32'h1234_5679;

  int     xr [NS];
  int     xi [NS];
  longint er [NPER];
  longint ei [NPER];
  int     eidx [NPER];
  int     tlast [NPER];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int unsigned nxt();
    lf = lf ^ (lf << 13);
    lf = lf ^ (lf >> 17);
    lf = lf ^ (lf << 5);
    return lf;
  endfunction

  // build a stream of symbols, each with a prefix copied from the useful tail
  task automatic build(input int off, input int mode);
    int ur [NFFT];
    int ui [NFFT];
    for (int g = 0; g < NS; g++) begin
      xr[g] = (mode == 2) ? -32768 : 0;
      xi[g] = (mode == 2) ? -32768 : 0;
    end
    if (mode != 2) begin
      for (int j = -1; j < NPER; j++) begin
        int base = off + j * SYM;
        for (int k = 0; k < NFFT; k++) begin
          int amp = (k >= NFFT - NCP) ? 8192 : 4096;
          ur[k] = nxt()[3] ? amp : -amp;
          ui[k] = nxt()[5] ? amp : -amp;
          if (base + NCP + k >= 0 && base + NCP + k < NS) begin
            xr[base + NCP + k] = ur[k];
            xi[base + NCP + k] = ui[k];
          end
        end
        for (int i = 0; i < NCP; i++) begin
          int p = base + i;
          if (p >= 0 && p < NS) begin
            if (mode == 1) begin
              xr[p] = ui[NFFT - NCP + i];
              xi[p] = -ur[NFFT - NCP + i];
            end else begin
              xr[p] = ur[NFFT - NCP + i];
              xi[p] = ui[NFFT - NCP + i];
            end
          end
        end
      end
    end
  endtask

  // brute-force window sums and first-maximum search per period
  task automatic model();
    longint best;
    for (int g = 0; g < NS; g++) begin
      longint sr = 0;
      longint si = 0;
      longint mg;
      int e = g % SYM;
      for (int m = g - NCP + 1; m <= g; m++) begin
        if (m >= NFFT) begin
          sr += longint'(xr[m]) * xr[m - NFFT] + longint'(xi[m]) * xi[m - NFFT];
          si += longint'(xi[m]) * xr[m - NFFT] - longint'(xr[m]) * xi[m - NFFT];
        end
      end
      mg = (sr < 0 ? -sr : sr) + (si < 0 ? -si : si);
      if (e == 0 || mg > best) begin
        best = mg;
        er[g / SYM] = sr;
        ei[g / SYM] = si;
        eidx[g / SYM] = (e + NCP + 1) % SYM;
      end
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk(sym_done == 1'b0, "R1 done in reset", sym_done, 0);
    chk(peak_idx == '0, "R1 idx in reset", peak_idx, 0);
    chk(peak_re == '0 && peak_im == '0, "R1 sum in reset", peak_re, 0);
    rst = 1'b0;
  endtask

  task automatic run_case(input int ci);
    int k = 0;
    int guard = 0;
    case_t c = CASES[ci];
    build(c.off, c.mode);
    model();
    do_reset();
    fork
      begin
        for (int g = 0; g < NS; g++) begin
          if (c.gaps != 0 && nxt() % 3 == 0) begin
            @(negedge clk);
            in_valid = 1'b0;
          end
          @(negedge clk);
          in_valid = 1'b1;
          in_re = DW'(xr[g]);
          in_im = DW'(xi[g]);
          if (g % SYM == SYM - 1) tlast[g / SYM] = cyc + 1;
        end
        @(negedge clk);
        in_valid = 1'b0;
      end
      begin
        while (k < NPER && guard < 2 * NS + 100) begin
          @(negedge clk);
          guard++;
          if (sym_done) begin
            // R5 R7 R10: index against the window model
            chk(int'(peak_idx) == eidx[k], $sformatf("R5 case %0d period %0d idx", ci, k), peak_idx, eidx[k]);
            // R2 R3 R6 R9: complex sum against the model
            chk(longint'(peak_re) == er[k], $sformatf("R2 R6 case %0d period %0d re", ci, k), longint'(peak_re), er[k]);
            chk(longint'(peak_im) == ei[k], $sformatf("R2 R6 case %0d period %0d im", ci, k), longint'(peak_im), ei[k]);
            // R4: strobe timing after the last sample of the period
            chk(cyc == tlast[k] + 3, $sformatf("R4 case %0d period %0d latency", ci, k), cyc, tlast[k] + 3);
            if (k == 1) begin
              chk(int'(peak_idx) == c.exp_idx, $sformatf("R5 R7 R10 case %0d table idx", ci), peak_idx, c.exp_idx);
              if (c.mode == 0) chk(peak_im == '0, "R6 pure delay im", longint'(peak_im), 0);
              if (c.mode == 1) chk(peak_re == '0 && peak_im > 0, "R6 R8 rotated prefix", longint'(peak_re), 0);
              if (c.mode == 2) chk(longint'(peak_re) == 64'sd144 * (64'sd1 <<< 31), "R3 full scale sum",
                                   longint'(peak_re), 64'sd144 * (64'sd1 <<< 31));
            end
            k++;
          end
        end
      end
    join
    chk(k == NPER, $sformatf("R4 case %0d strobe count", ci), k, NPER);
  endtask

  // directed: reset mid-period restarts the period count (R1, R4)
  task automatic mid_reset();
    int seen = 0;
    int t = 0;
    build(0, 0);
    do_reset();
    for (int g = 0; g < 150; g++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_re = DW'(xr[g]);
      in_im = DW'(xi[g]);
    end
    do_reset();
    for (int g = 0; g < SYM - 1; g++) begin
      @(negedge clk);
      if (sym_done) seen++;
      in_valid = 1'b1;
      in_re = DW'(xr[g]);
      in_im = DW'(xi[g]);
    end
    repeat (4) begin
      @(negedge clk);
      if (sym_done) seen++;
      in_valid = 1'b0;
    end
    chk(seen == 0, "R1 R4 no strobe before full period", seen, 0);
    @(negedge clk);
    in_valid = 1'b1;
    in_re = DW'(xr[SYM - 1]);
    in_im = DW'(xi[SYM - 1]);
    t = cyc + 1;
    @(negedge clk);
    in_valid = 1'b0;
    while (!sym_done && cyc < t + 10) @(negedge clk);
    chk(sym_done && cyc == t + 3, "R4 strobe after restart", cyc, t + 3);
  endtask

  initial begin
    for (int ci = 0; ci < NCASE; ci++) run_case(ci);
    mid_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule